// File: doc/BRIEF.md
# Lockable controller configuration registers

This block holds the run-time configuration of a floppy-style disk controller: a FIFO disable flag, a FIFO threshold and the track at which write precompensation starts. A perpendicular-recording setting and a lock flag sit beside them. Firmware loads the settings one byte at a time over a valid/ready command port. A result port returns bytes with the same handshake. The three configuration fields also drive dedicated outputs to the rest of the controller.

The block takes two kinds of reset. The asynchronous hardware reset pin restores every field and clears the lock flag. The single-cycle software reset abandons any command in progress. When the lock flag is clear, it also returns the three configuration fields to their defaults. When the lock flag is set, the fields keep the values they had. Only the configure command can turn the FIFO off; the lock command leaves the FIFO settings alone. A register-dump command reads back every stored value, and its eighth byte carries the lock flag next to the perpendicular setting.

Top module: `cfg_lock_regs`

## Requirements
- R1: After the hardware reset pin is asserted, the fields take these values: fifo_dis_o = 1, fifo_thr_o = 0, precomp_trk_o = 0, lock_o = 0 and perpendicular setting = 0. Also cmd_ready_o = 1 and res_valid_o = 0.
- R2: A byte whose low five bits are 0x13 starts a configure command. Three parameter bytes follow. The first is ignored. The second carries FIFO disable in bit 5 (1 = FIFO off) and the threshold in bits 3:0. The third is the precompensation start track. All three fields change together at the edge that accepts the third byte. The command returns no result byte.
- R3: A byte whose low five bits are 0x14 is a lock command, and its bit 7 is the new lock value. lock_o takes that value at the accepting edge. Exactly one result byte follows. That byte carries the new lock value in bit 4, and all its other bits are 0.
- R4: A software reset while lock_o = 1 leaves fifo_dis_o, fifo_thr_o and precomp_trk_o unchanged.
- R5: A software reset while lock_o = 0 returns fifo_dis_o to 1, fifo_thr_o to 0 and precomp_trk_o to 0 on the next edge.
- R6: A software reset never changes lock_o.
- R7: A software reset abandons a partly received command and discards any result bytes not yet read. On the next cycle cmd_ready_o = 1 and res_valid_o = 0, and the next accepted byte is decoded as an opcode.
- R8: A byte whose low five bits are 0x12 takes one parameter byte and stores its bits 5:0 as the perpendicular setting. A software reset clears setting bits 1:0 and keeps bits 5:2, whatever the lock state.
- R9: A byte whose low five bits are 0x0E returns ten dump bytes. Bytes 0 to 6 are 0. Byte 7 is {lock, 0, perpendicular[5:0]}. Byte 8 is {00, FIFO disable, 0, threshold[3:0]}. Byte 9 is the precompensation track.
- R10: Any other opcode returns the single result byte 0x80 and changes no stored field.
- R11: A lock command never changes fifo_dis_o, fifo_thr_o or precomp_trk_o.
- R12: While result bytes are pending, cmd_ready_o is 0. res_data_o holds steady while res_valid_o = 1 and res_ready_i = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, asynchronous assert, active low |
| sw_rst_i | input | 1 | Software reset, one-cycle pulse |
| cmd_valid_i | input | 1 | Command byte valid |
| cmd_ready_o | output | 1 | Command byte can be accepted |
| cmd_data_i | input | 8 | Command or parameter byte |
| res_valid_o | output | 1 | Result byte valid |
| res_ready_i | input | 1 | Result byte taken |
| res_data_o | output | 8 | Result byte |
| fifo_dis_o | output | 1 | FIFO disabled (1 = off) |
| fifo_thr_o | output | 4 | FIFO threshold |
| precomp_trk_o | output | 8 | Precompensation start track |
| lock_o | output | 1 | Lock flag |

## Verification
On every cycle, the assertions check how a software reset treats the stored fields. Locked fields must hold, unlocked fields must return to their defaults, and the lock flag must never move. They also check that a lock write never disturbs the configuration fields, that a reset empties the result path, and that a stalled result byte stays steady. The bench scenarios cover the rest: the byte layouts of the configure, perpendicular and dump commands, the exact lock result byte, the reply to an unknown opcode, and that a configure command takes effect only on its third byte. They also show that an interrupted command loses its state and that a hardware reset still clears a set lock.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;
  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned THR_W       = 4;
  localparam int unsigned TRK_W       = 8;
  localparam int unsigned PERP_W      = 6;
  localparam int unsigned OPC_W       = 5;
  localparam int unsigned DUMP_BYTES  = 10;
  localparam int unsigned CFG_PARAMS  = 3;
  localparam int unsigned IDX_W       = $clog2(DUMP_BYTES);
  localparam int unsigned PCNT_W      = $clog2(CFG_PARAMS);
  localparam int unsigned LOCK_CMD_BIT = 7;
  localparam int unsigned LOCK_RES_BIT = 4;
  localparam int unsigned FDIS_BIT    = 5;
  localparam int unsigned PERP_KEEP_LO = 2;

  localparam logic [OPC_W-1:0] OPC_CONFIG = 5'h13;
  localparam logic [OPC_W-1:0] OPC_LOCK   = 5'h14;
  localparam logic [OPC_W-1:0] OPC_PERP   = 5'h12;
  localparam logic [OPC_W-1:0] OPC_DUMP   = 5'h0E;
  localparam logic [BYTE_W-1:0] BAD_OPC_RESP = 8'h80;

  localparam int unsigned DUMP_IDX_LOCK = 7;
  localparam int unsigned DUMP_IDX_FIFO = 8;
  localparam int unsigned DUMP_IDX_TRK  = 9;

  typedef enum logic [1:0] {SQ_IDLE, SQ_PARAM, SQ_RESULT} seq_state_e;
  typedef enum logic [1:0] {RK_LOCK, RK_DUMP, RK_BAD} res_kind_e;
  typedef enum logic {PK_CONFIG, PK_PERP} par_kind_e;

  typedef struct packed {
    logic             fifo_dis;
    logic [THR_W-1:0] thr;
    logic [TRK_W-1:0] trk;
  } cfg_fields_t;

  localparam cfg_fields_t CFG_DEFAULT = '{fifo_dis: 1'b1, thr: '0, trk: '0};
endpackage

// File: rtl/cfgl_regs.sv
module cfgl_regs
  import cfgl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_rst_i,
  input  logic              cfg_we_i,
  input  cfg_fields_t       cfg_wdata_i,
  input  logic              perp_we_i,
  input  logic [PERP_W-1:0] perp_wdata_i,
  input  logic              lock_we_i,
  input  logic              lock_wdata_i,
  output cfg_fields_t       cfg_q_o,
  output logic [PERP_W-1:0] perp_q_o,
  output logic              lock_q_o
);
  cfg_fields_t       cfg_q, cfg_n;
  logic [PERP_W-1:0] perp_q, perp_n;
  logic              lock_q, lock_n;
  logic              cfg_en, perp_en, lock_en;

  always_comb begin
    cfg_n   = cfg_q;
    perp_n  = perp_q;
    lock_n  = lock_q;
    cfg_en  = 1'b0;
    perp_en = 1'b0;
    lock_en = 1'b0;
    if (sw_rst_i) begin
      if (!lock_q) begin
        cfg_n  = CFG_DEFAULT;
        cfg_en = 1'b1;
      end
      perp_n  = {perp_q[PERP_W-1:PERP_KEEP_LO], {PERP_KEEP_LO{1'b0}}};
      perp_en = 1'b1;
    end else begin
      if (cfg_we_i) begin
        cfg_n  = cfg_wdata_i;
        cfg_en = 1'b1;
      end
      if (perp_we_i) begin
        perp_n  = perp_wdata_i;
        perp_en = 1'b1;
      end
      if (lock_we_i) begin
        lock_n  = lock_wdata_i;
        lock_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= CFG_DEFAULT;
      perp_q <= '0;
      lock_q <= 1'b0;
    end else begin
      if (cfg_en)  cfg_q  <= cfg_n;
      if (perp_en) perp_q <= perp_n;
      if (lock_en) lock_q <= lock_n;
    end
  end

  assign cfg_q_o  = cfg_q;
  assign perp_q_o = perp_q;
  assign lock_q_o = lock_q;

  // R4: locked fields survive a software reset
  assert_locked_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_rst_i && lock_q) |=> $stable(cfg_q));
  // R5: unlocked fields return to defaults
  assert_unlocked_default_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_rst_i && !lock_q) |=> (cfg_q == CFG_DEFAULT));
  // R6: software reset leaves the lock flag alone
  assert_lock_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst_i |=> $stable(lock_q));
  // R8: upper perpendicular bits survive a software reset, low bits clear
  assert_perp_swrst_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst_i |=> (perp_q[PERP_KEEP_LO-1:0] == '0) &&
                 (perp_q[PERP_W-1:PERP_KEEP_LO] == $past(perp_q[PERP_W-1:PERP_KEEP_LO])));
  // R3: a lock write takes the commanded value
  assert_lock_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_we_i && !sw_rst_i) |=> (lock_q == $past(lock_wdata_i)));
endmodule

// File: rtl/cfgl_seq.sv
module cfgl_seq
  import cfgl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_rst_i,
  input  logic              cmd_valid_i,
  input  logic [BYTE_W-1:0] cmd_data_i,
  output logic              cmd_ready_o,
  output logic              res_valid_o,
  input  logic              res_ready_i,
  output res_kind_e         res_kind_o,
  output logic [IDX_W-1:0]  res_idx_o,
  output logic              cfg_we_o,
  output cfg_fields_t       cfg_wdata_o,
  output logic              perp_we_o,
  output logic [PERP_W-1:0] perp_wdata_o,
  output logic              lock_we_o,
  output logic              lock_wdata_o
);
  localparam logic [IDX_W-1:0]  LAST_DUMP  = IDX_W'(DUMP_BYTES - 1);
  localparam logic [PCNT_W-1:0] LAST_PARAM = PCNT_W'(CFG_PARAMS - 1);
  localparam logic [PCNT_W-1:0] STAGE_PARAM = PCNT_W'(1);

  seq_state_e            state_q, state_n;
  par_kind_e             pkind_q, pkind_n;
  res_kind_e             rkind_q, rkind_n;
  logic [PCNT_W-1:0]     pcnt_q, pcnt_n;
  logic [IDX_W-1:0]      idx_q, idx_n;
  logic [IDX_W-1:0]      last_q, last_n;
  logic                  stg_dis_q, stg_dis_n;
  logic [THR_W-1:0]      stg_thr_q, stg_thr_n;
  logic                  cmd_fire, res_fire;
  logic [OPC_W-1:0]      opc;

  assign cmd_ready_o = (state_q != SQ_RESULT);
  assign res_valid_o = (state_q == SQ_RESULT);
  assign cmd_fire    = cmd_valid_i && cmd_ready_o;
  assign res_fire    = res_valid_o && res_ready_i;
  assign opc         = cmd_data_i[OPC_W-1:0];

  assign cfg_wdata_o  = '{fifo_dis: stg_dis_q, thr: stg_thr_q, trk: cmd_data_i[TRK_W-1:0]};
  assign perp_wdata_o = cmd_data_i[PERP_W-1:0];
  assign lock_wdata_o = cmd_data_i[LOCK_CMD_BIT];

  always_comb begin
    state_n   = state_q;
    pkind_n   = pkind_q;
    rkind_n   = rkind_q;
    pcnt_n    = pcnt_q;
    idx_n     = idx_q;
    last_n    = last_q;
    stg_dis_n = stg_dis_q;
    stg_thr_n = stg_thr_q;
    cfg_we_o  = 1'b0;
    perp_we_o = 1'b0;
    lock_we_o = 1'b0;
    if (sw_rst_i) begin
      state_n = SQ_IDLE;
      pcnt_n  = '0;
      idx_n   = '0;
    end else begin
      case (state_q)
        SQ_IDLE: begin
          if (cmd_fire) begin
            pcnt_n = '0;
            idx_n  = '0;
            last_n = '0;
            case (opc)
              OPC_CONFIG: begin
                state_n = SQ_PARAM;
                pkind_n = PK_CONFIG;
              end
              OPC_PERP: begin
                state_n = SQ_PARAM;
                pkind_n = PK_PERP;
              end
              OPC_LOCK: begin
                lock_we_o = 1'b1;
                state_n   = SQ_RESULT;
                rkind_n   = RK_LOCK;
              end
              OPC_DUMP: begin
                state_n = SQ_RESULT;
                rkind_n = RK_DUMP;
                last_n  = LAST_DUMP;
              end
              default: begin
                state_n = SQ_RESULT;
                rkind_n = RK_BAD;
              end
            endcase
          end
        end
        SQ_PARAM: begin
          if (cmd_fire) begin
            if (pkind_q == PK_PERP) begin
              perp_we_o = 1'b1;
              state_n   = SQ_IDLE;
            end else begin
              pcnt_n = pcnt_q + 1'b1;
              if (pcnt_q == STAGE_PARAM) begin
                stg_dis_n = cmd_data_i[FDIS_BIT];
                stg_thr_n = cmd_data_i[THR_W-1:0];
              end
              if (pcnt_q == LAST_PARAM) begin
                cfg_we_o = 1'b1;
                state_n  = SQ_IDLE;
              end
            end
          end
        end
        SQ_RESULT: begin
          if (res_fire) begin
            if (idx_q == last_q) state_n = SQ_IDLE;
            else                 idx_n   = idx_q + 1'b1;
          end
        end
        default: state_n = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SQ_IDLE;
      pkind_q   <= PK_CONFIG;
      rkind_q   <= RK_BAD;
      pcnt_q    <= '0;
      idx_q     <= '0;
      last_q    <= '0;
      stg_dis_q <= 1'b1;
      stg_thr_q <= '0;
    end else begin
      state_q   <= state_n;
      pkind_q   <= pkind_n;
      rkind_q   <= rkind_n;
      pcnt_q    <= pcnt_n;
      idx_q     <= idx_n;
      last_q    <= last_n;
      stg_dis_q <= stg_dis_n;
      stg_thr_q <= stg_thr_n;
    end
  end

  assign res_kind_o = rkind_q;
  assign res_idx_o  = idx_q;

  // R7: software reset empties the result path and reopens the command port
  assert_swrst_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst_i |=> (!res_valid_o && cmd_ready_o));
  // R3: a lock reply is a single byte
  assert_lock_one_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_fire && rkind_q == RK_LOCK && !sw_rst_i) |=> !res_valid_o);
  // R12: a command byte is never accepted while results are pending
  assert_no_cmd_in_result_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && !res_fire && !sw_rst_i) |=> !cmd_ready_o);
endmodule

// File: rtl/cfgl_resp.sv
module cfgl_resp
  import cfgl_pkg::*;
(
  input  res_kind_e         res_kind_i,
  input  logic [IDX_W-1:0]  res_idx_i,
  input  cfg_fields_t       cfg_i,
  input  logic [PERP_W-1:0] perp_i,
  input  logic              lock_i,
  output logic [BYTE_W-1:0] res_data_o
);
  localparam int unsigned FIFO_PAD = BYTE_W - 2 - THR_W;
  localparam int unsigned PERP_PAD = BYTE_W - 1 - PERP_W;

  logic [BYTE_W-1:0] dump_b [DUMP_BYTES];
  logic [BYTE_W-1:0] lock_b;

  for (genvar g = 0; g < DUMP_BYTES; g++) begin : g_dump
    if (g == DUMP_IDX_LOCK) begin : g_lock
      assign dump_b[g] = {lock_i, {PERP_PAD{1'b0}}, perp_i};
    end else if (g == DUMP_IDX_FIFO) begin : g_fifo
      assign dump_b[g] = {{FIFO_PAD{1'b0}}, cfg_i.fifo_dis, 1'b0, cfg_i.thr};
    end else if (g == DUMP_IDX_TRK) begin : g_trk
      assign dump_b[g] = BYTE_W'(cfg_i.trk);
    end else begin : g_zero
      assign dump_b[g] = '0;
    end
  end

  always_comb begin
    lock_b = '0;
    lock_b[LOCK_RES_BIT] = lock_i;
  end

  always_comb begin
    case (res_kind_i)
      RK_LOCK: res_data_o = lock_b;
      RK_DUMP: res_data_o = (int'(res_idx_i) < DUMP_BYTES) ? dump_b[res_idx_i] : '0;
      default: res_data_o = BAD_OPC_RESP;
    endcase
  end
endmodule

// File: rtl/cfg_lock_regs.sv
module cfg_lock_regs
  import cfgl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sw_rst_i,
  input  logic        cmd_valid_i,
  output logic        cmd_ready_o,
  input  logic [7:0]  cmd_data_i,
  output logic        res_valid_o,
  input  logic        res_ready_i,
  output logic [7:0]  res_data_o,
  output logic        fifo_dis_o,
  output logic [3:0]  fifo_thr_o,
  output logic [7:0]  precomp_trk_o,
  output logic        lock_o
);
  res_kind_e         res_kind;
  logic [IDX_W-1:0]  res_idx;
  logic              cfg_we, perp_we, lock_we, lock_wdata;
  cfg_fields_t       cfg_wdata, cfg_q;
  logic [PERP_W-1:0] perp_wdata, perp_q;
  logic              lock_q;

  cfgl_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .sw_rst_i     (sw_rst_i),
    .cmd_valid_i  (cmd_valid_i),
    .cmd_data_i   (cmd_data_i),
    .cmd_ready_o  (cmd_ready_o),
    .res_valid_o  (res_valid_o),
    .res_ready_i  (res_ready_i),
    .res_kind_o   (res_kind),
    .res_idx_o    (res_idx),
    .cfg_we_o     (cfg_we),
    .cfg_wdata_o  (cfg_wdata),
    .perp_we_o    (perp_we),
    .perp_wdata_o (perp_wdata),
    .lock_we_o    (lock_we),
    .lock_wdata_o (lock_wdata)
  );

  cfgl_regs u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .sw_rst_i     (sw_rst_i),
    .cfg_we_i     (cfg_we),
    .cfg_wdata_i  (cfg_wdata),
    .perp_we_i    (perp_we),
    .perp_wdata_i (perp_wdata),
    .lock_we_i    (lock_we),
    .lock_wdata_i (lock_wdata),
    .cfg_q_o      (cfg_q),
    .perp_q_o     (perp_q),
    .lock_q_o     (lock_q)
  );

  cfgl_resp u_resp (
    .res_kind_i (res_kind),
    .res_idx_i  (res_idx),
    .cfg_i      (cfg_q),
    .perp_i     (perp_q),
    .lock_i     (lock_q),
    .res_data_o (res_data_o)
  );

  assign fifo_dis_o    = cfg_q.fifo_dis;
  assign fifo_thr_o    = cfg_q.thr;
  assign precomp_trk_o = cfg_q.trk;
  assign lock_o        = lock_q;

  // R11: a lock write leaves the configuration outputs alone
  assert_lock_keeps_cfg_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_we && !sw_rst_i) |=> ($stable(fifo_dis_o) && $stable(fifo_thr_o) && $stable(precomp_trk_o)));
  // R12: a stalled result byte holds
  assert_res_stall_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && !res_ready_i && !sw_rst_i) |=> $stable(res_data_o));
endmodule

// File: tb/cfg_lock_regs_tb_top.sv
module cfg_lock_regs_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sw_rst_i = 1'b0;
  logic       cmd_valid_i = 1'b0;
  logic       cmd_ready_o;
  logic [7:0] cmd_data_i = 8'h00;
  logic       res_valid_o;
  logic       res_ready_i = 1'b0;
  logic [7:0] res_data_o;
  logic       fifo_dis_o;
  logic [3:0] fifo_thr_o;
  logic [7:0] precomp_trk_o;
  logic       lock_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cfg_lock_regs dut_i (
    .clk(clk), .rst_n(rst_n), .sw_rst_i(sw_rst_i),
    .cmd_valid_i(cmd_valid_i), .cmd_ready_o(cmd_ready_o), .cmd_data_i(cmd_data_i),
    .res_valid_o(res_valid_o), .res_ready_i(res_ready_i), .res_data_o(res_data_o),
    .fifo_dis_o(fifo_dis_o), .fifo_thr_o(fifo_thr_o), .precomp_trk_o(precomp_trk_o),
    .lock_o(lock_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic check_cfg(input string tag, input bit dis, input int thr, input int trk);
    check(fifo_dis_o == dis, {tag, " fifo_dis"}, fifo_dis_o, dis);
    check(fifo_thr_o == thr[3:0], {tag, " thr"}, fifo_thr_o, thr);
    check(precomp_trk_o == trk[7:0], {tag, " trk"}, precomp_trk_o, trk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    cmd_valid_i = 1'b1;
    cmd_data_i  = b;
    while (!cmd_ready_o) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cmd_valid_i = 1'b0;
  endtask

  task automatic recv_byte(output logic [7:0] b);
    @(negedge clk);
    res_ready_i = 1'b1;
    while (!res_valid_o) @(negedge clk);
    b = res_data_o;
    @(posedge clk);
    @(negedge clk);
    res_ready_i = 1'b0;
  endtask

  task automatic pulse_swrst();
    @(negedge clk);
    sw_rst_i = 1'b1;
    @(negedge clk);
    sw_rst_i = 1'b0;
  endtask

  task automatic hw_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_config(input logic [7:0] opc, input logic [7:0] p2, input logic [7:0] p3);
    send_byte(opc);
    send_byte(8'hA5);
    send_byte(p2);
    send_byte(p3);
  endtask

  task automatic do_lock(input bit v, input string tag);
    logic [7:0] r;
    send_byte({v, 2'b00, 5'h14});
    check(lock_o == v, {tag, " lock_o"}, lock_o, v);
    recv_byte(r);
    check(r == {3'b000, v, 4'b0000}, {tag, " result"}, r, {3'b000, v, 4'b0000});
    @(negedge clk);
    check(!res_valid_o && cmd_ready_o, {tag, " single byte"}, res_valid_o, 0);
  endtask

  task automatic t_reset_state();
    check_cfg("R1 reset", 1'b1, 0, 0);
    check(lock_o == 1'b0, "R1 lock", lock_o, 0);
    check(cmd_ready_o && !res_valid_o, "R1 handshake", {cmd_ready_o, res_valid_o}, 2);
  endtask

  task automatic t_configure();
    send_byte(8'h13);
    send_byte(8'hFF);
    send_byte(8'h07);
    check_cfg("R2 not yet applied", 1'b1, 0, 0);
    send_byte(8'h2A);
    check_cfg("R2 applied", 1'b0, 7, 8'h2A);
    check(!res_valid_o, "R2 no result", res_valid_o, 0);
    do_config(8'hF3, 8'h2C, 8'h11);
    check_cfg("R2 high opcode bits", 1'b1, 12, 8'h11);
  endtask

  task automatic t_lock();
    do_config(8'h13, 8'h05, 8'h33);
    do_lock(1'b1, "R3 set");
    check_cfg("R11 after lock set", 1'b0, 5, 8'h33);
    do_lock(1'b0, "R3 clear");
    check_cfg("R11 after lock clear", 1'b0, 5, 8'h33);
  endtask

  task automatic t_swrst_locked();
    do_config(8'h13, 8'h09, 8'h40);
    do_lock(1'b1, "R4 prep");
    pulse_swrst();
    check_cfg("R4 locked hold", 1'b0, 9, 8'h40);
    check(lock_o == 1'b1, "R6 lock kept set", lock_o, 1);
  endtask

  task automatic t_swrst_unlocked();
    do_lock(1'b0, "R5 prep");
    do_config(8'h13, 8'h0E, 8'h50);
    pulse_swrst();
    check_cfg("R5 defaults", 1'b1, 0, 0);
    check(lock_o == 1'b0, "R6 lock kept clear", lock_o, 0);
  endtask

  task automatic t_abort();
    logic [7:0] r;
    send_byte(8'h13);
    send_byte(8'h00);
    pulse_swrst();
    check(cmd_ready_o && !res_valid_o, "R7 ready after abort", {cmd_ready_o, res_valid_o}, 2);
    send_byte(8'h1F);
    recv_byte(r);
    check(r == 8'h80, "R7 next byte is opcode", r, 8'h80);
    send_byte(8'h0E);
    recv_byte(r);
    recv_byte(r);
    pulse_swrst();
    check(!res_valid_o && cmd_ready_o, "R7 results flushed", res_valid_o, 0);
  endtask

  task automatic read_dump(output logic [7:0] d [10]);
    send_byte(8'h0E);
    for (int i = 0; i < 10; i++) recv_byte(d[i]);
  endtask

  task automatic t_perp_and_dump();
    logic [7:0] d [10];
    send_byte(8'h12);
    send_byte(8'hFF);
    do_lock(1'b1, "R9 prep");
    do_config(8'h13, 8'h06, 8'h77);
    read_dump(d);
    for (int i = 0; i < 7; i++) check(d[i] == 8'h00, "R9 zero byte", d[i], 0);
    check(d[7] == 8'hBF, "R8 R9 byte7", d[7], 8'hBF);
    check(d[8] == 8'h06, "R9 byte8", d[8], 8'h06);
    check(d[9] == 8'h77, "R9 byte9", d[9], 8'h77);
    @(negedge clk);
    check(!res_valid_o, "R9 ten bytes only", res_valid_o, 0);
    pulse_swrst();
    read_dump(d);
    check(d[7] == 8'hBC, "R8 perp after swrst", d[7], 8'hBC);
    check(d[8] == 8'h06, "R4 dump after swrst", d[8], 8'h06);
    do_lock(1'b0, "R9 unlock");
    do_config(8'h13, 8'h2F, 8'h01);
    read_dump(d);
    check(d[7] == 8'h3C, "R9 byte7 unlocked", d[7], 8'h3C);
    check(d[8] == 8'h2F, "R9 byte8 fifo off", d[8], 8'h2F);
  endtask

  task automatic t_invalid();
    logic [7:0] r;
    send_byte(8'h01);
    recv_byte(r);
    check(r == 8'h80, "R10 response", r, 8'h80);
    @(negedge clk);
    check(!res_valid_o, "R10 single byte", res_valid_o, 0);
    check_cfg("R10 no change", 1'b1, 15, 8'h01);
  endtask

  task automatic t_handshake();
    logic [7:0] r;
    logic [7:0] first;
    send_byte(8'h0E);
    for (int i = 0; i < 7; i++) recv_byte(r);
    @(negedge clk);
    first = res_data_o;
    check(!cmd_ready_o, "R12 ready low", cmd_ready_o, 0);
    repeat (3) @(negedge clk);
    check(res_data_o == first && res_valid_o, "R12 stall stable", res_data_o, first);
    for (int i = 0; i < 3; i++) recv_byte(r);
    @(negedge clk);
    check(cmd_ready_o, "R12 ready restored", cmd_ready_o, 1);
  endtask

  task automatic t_hw_reset();
    do_config(8'h13, 8'h03, 8'h99);
    do_lock(1'b1, "R1 prep");
    hw_reset();
    check_cfg("R1 hw reset defaults", 1'b1, 0, 0);
    check(lock_o == 1'b0, "R1 hw reset lock", lock_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_configure();
    t_lock();
    t_swrst_locked();
    t_swrst_unlocked();
    t_abort();
    t_perp_and_dump();
    t_invalid();
    t_handshake();
    t_hw_reset();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule